// File: doc/BRIEF.md
# Configurable UART with Baud Select

This block is a full-duplex asynchronous serial port. A shared baud generator produces a timing tick at sixteen times the chosen bit rate; a three-bit rate field picks one of eight rates, each half the previous one. With the default divider and a clock of about 19.7 MHz, the fastest setting is about 38.46 kbit/s and the slowest is about 300 bit/s. Both the transmitter and the receiver count these ticks, so one bit lasts sixteen ticks.

A frame is a low start bit, then 6, 7 or 8 data bits sent least significant first, then an optional parity bit, then a high stop bit. Between frames the line rests high. The transmitter works from a single holding register. When it takes a word from that register it marks the register empty, so the CPU can queue the next word while the current one shifts out, and the frames then follow without a gap. The receiver synchronises the line and confirms a start edge at the mid-point of the start bit. It samples each later bit once at its centre, and it then places the symbol, right aligned, in a receive data register with a full flag and parity and framing error flags.

A CPU reaches the block through a two-bit address with write and read strobes. There are two interrupt lines: receive data ready and transmit holding register empty. Each line has its own enable bit.

Top module: `serial_port_core`

## Requirements
- R1: The bit time is 16 × BASE_DIV × 2^rate clock cycles, where rate is control bits [2:0]. Rate 000 is the fastest, and each step doubles the bit time.
- R2: A frame sent on `txd` is a 0 start bit, then the data bits least significant first, then the parity bit when enabled, then a 1 stop bit. `txd` is 1 when nothing is being sent.
- R3: The symbol length comes from control bits [4:3]: 00 or 11 gives 8 bits, 01 gives 7 and 10 gives 6. A received symbol is right aligned in the data register, with its unused upper bits 0.
- R4: Control bit 5 enables parity and control bit 6 selects odd parity. The parity bit makes the count of ones over the data and parity bits even when bit 6 is 0, and odd when bit 6 is 1.
- R5: A write to address 0 fills the transmit holding register and clears status bit 1. When the transmitter takes the word, status bit 1 returns to 1. A word queued while a frame is in flight starts the next frame right after the stop bit, and that stop bit lasts exactly one bit time.
- R6: After a frame's stop bit the receiver loads address 0's read data and sets status bit 0. A read of address 0 clears status bit 0.
- R7: A parity mismatch sets status bit 2 and a low stop bit sets status bit 3. Both flags are loaded with each received frame and cleared by a read of address 0. After a low stop bit the receiver waits for the line to go high before it looks for a new start.
- R8: A low pulse on `rxd` that has ended by the 8th tick after its falling edge produces no frame.
- R9: `irq_rx` is status bit 0 gated by address 2 bit 0. `irq_tx` is status bit 1 gated by address 2 bit 1.
- R10: After reset `txd` is 1, both interrupt lines are 0, and status (address 3) reads 0x02. Status bit 4 is 1 while the transmitter is sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | 0 data, 1 control, 2 interrupt enables, 3 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |
| irq_rx | output | 1 | Receive data ready interrupt |
| irq_tx | output | 1 | Transmit holding register empty interrupt |

## Verification
The assertions check on every cycle that ticks never come back to back, that `txd` moves only on a tick or a frame load, that each frame begins with a low start bit, that a queued word stays held until taken, that a read of the data register clears the full flag, that a start sample seen high sends the receiver back to idle, and that data is committed only from the stop-bit state. Only the bench scenarios can show the whole frame format for each length and parity setting, the measured bit time at two rates, loopback data that arrives intact, the exact length of the stop bit between back-to-back frames, the parity and framing error flags with their recovery after a break, and the gating of the interrupts.

// File: rtl/asp_pkg.sv
package asp_pkg;

    localparam int FRAME_MAX = 11;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BRK
    } rx_state_t;

    // control register layout: {podd, pen, len_code[1:0], rate[2:0]}
    typedef struct packed {
        logic       podd;
        logic       pen;
        logic [1:0] len_code;
        logic [2:0] rate;
    } cfg_t;

    typedef struct packed {
        logic       pe;
        logic       fe;
        logic [7:0] data;
    } rx_word_t;

    function automatic logic [3:0] sym_len(input logic [1:0] code);
        case (code)
            2'd1:    return 4'd7;
            2'd2:    return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [7:0] len_mask(input logic [3:0] n);
        return 8'hFF >> (4'd8 - n);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic [3:0] n,
                                    input logic odd);
        return odd ^ (^(d & len_mask(n)));
    endfunction

    function automatic logic [3:0] frame_bits(input cfg_t c);
        return 4'd2 + sym_len(c.len_code) + {3'd0, c.pen};
    endfunction

    // line bits in send order, bit 0 first; unused positions are 1
    function automatic logic [FRAME_MAX-1:0] make_frame(input logic [7:0] d,
                                                        input cfg_t c);
        logic [FRAME_MAX-1:0] f;
        logic [3:0] n;
        n = sym_len(c.len_code);
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++)
            if (i < int'(n)) f[i+1] = d[i];
        if (c.pen) f[n+1] = par_of(d, n, c.podd);
        return f;
    endfunction

endpackage

// File: rtl/asp_baud.sv
module asp_baud #(
    parameter int BASE_DIV = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] rate,
    output logic       tick
);
    localparam int CW = $clog2(BASE_DIV * 128) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = (CW'(BASE_DIV) << rate) - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/asp_tx.sv
module asp_tx
    import asp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  cfg_t       cfg,
    input  logic       hold_full,
    input  logic [7:0] hold_data,
    output logic       take,
    output logic       busy,
    output logic       txd
);
    logic [FRAME_MAX-1:0] sh;
    logic [3:0]           left;
    logic [3:0]           tcnt;
    logic                 bit_end;

    assign bit_end = busy && tick && (tcnt == 4'd15);
    assign take    = hold_full && (!busy || (bit_end && left == 4'd1));
    assign txd     = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
            tcnt <= '0;
        end else if (take) begin
            busy <= 1'b1;
            sh   <= make_frame(hold_data, cfg);
            left <= frame_bits(cfg);
            tcnt <= '0;
        end else if (busy && tick) begin
            if (tcnt == 4'd15) begin
                tcnt <= '0;
                if (left == 4'd1) begin
                    busy <= 1'b0;
                end else begin
                    sh   <= {1'b1, sh[FRAME_MAX-1:1]};
                    left <= left - 1'b1;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !txd);
    // R1
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> ($past(tick) || $past(take)));

endmodule

// File: rtl/asp_rx.sv
module asp_rx
    import asp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  cfg_t     cfg,
    input  logic     rxd,
    output logic     done,
    output rx_word_t word
);
    rx_state_t  state;
    logic       s1, s2;
    logic [3:0] cnt;
    logic [3:0] nrx;
    logic [7:0] sr;
    logic       pbit;
    logic [3:0] len;
    logic [7:0] aligned;

    assign len     = sym_len(cfg.len_code);
    assign aligned = sr >> (4'd8 - len);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            cnt   <= '0;
            nrx   <= '0;
            sr    <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                RX_IDLE: if (!s2) begin
                    state <= RX_START;
                    cnt   <= '0;
                end
                RX_START: if (tick) begin
                    if (cnt == 4'd7) begin
                        cnt <= '0;
                        nrx <= '0;
                        state <= s2 ? RX_IDLE : RX_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                RX_DATA: if (tick) begin
                    if (cnt == 4'd15) begin
                        cnt <= '0;
                        sr  <= {s2, sr[7:1]};
                        nrx <= nrx + 1'b1;
                        if (nrx == len - 1'b1)
                            state <= cfg.pen ? RX_PAR : RX_STOP;
                    end else cnt <= cnt + 1'b1;
                end
                RX_PAR: if (tick) begin
                    if (cnt == 4'd15) begin
                        cnt   <= '0;
                        pbit  <= s2;
                        state <= RX_STOP;
                    end else cnt <= cnt + 1'b1;
                end
                RX_STOP: if (tick) begin
                    if (cnt == 4'd15) begin
                        cnt       <= '0;
                        done      <= 1'b1;
                        word.data <= aligned;
                        word.pe   <= cfg.pen && (pbit != par_of(aligned, len, cfg.podd));
                        word.fe   <= !s2;
                        state     <= s2 ? RX_IDLE : RX_BRK;
                    end else cnt <= cnt + 1'b1;
                end
                RX_BRK: if (s2) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R8
    glitch_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick && cnt == 4'd7 && s2) |=> state == RX_IDLE);
    // R6
    commit_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state == RX_STOP));

endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
    import asp_pkg::*;
#(
    parameter int BASE_DIV = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       txd,
    input  logic       rxd,
    output logic       irq_rx,
    output logic       irq_tx
);
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_IEN  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    cfg_t       cfg;
    logic [1:0] ien;
    logic [7:0] hold_data;
    logic       hold_full;
    rx_word_t   rx_word;
    rx_word_t   rx_new;
    logic       rx_full;
    logic       rx_done;
    logic       tick;
    logic       take;
    logic       tx_busy;
    logic       data_rd;
    logic       data_wr;

    assign data_rd = rd_en && addr == A_DATA;
    assign data_wr = wr_en && addr == A_DATA;

    asp_baud #(.BASE_DIV(BASE_DIV)) baud_i (
        .clk(clk), .rst(rst), .rate(cfg.rate), .tick(tick));

    asp_tx tx_i (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg),
        .hold_full(hold_full), .hold_data(hold_data),
        .take(take), .busy(tx_busy), .txd(txd));

    asp_rx rx_i (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .rxd(rxd),
        .done(rx_done), .word(rx_new));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            ien       <= '0;
            hold_data <= '0;
            hold_full <= 1'b0;
            rx_word   <= '0;
            rx_full   <= 1'b0;
        end else begin
            if (wr_en && addr == A_CTRL) cfg <= cfg_t'(wdata[6:0]);
            if (wr_en && addr == A_IEN)  ien <= wdata[1:0];
            if (take) hold_full <= 1'b0;
            if (data_wr) begin
                hold_full <= 1'b1;
                hold_data <= wdata;
            end
            if (rx_done) begin
                rx_word <= rx_new;
                rx_full <= 1'b1;
            end else if (data_rd) begin
                rx_full    <= 1'b0;
                rx_word.pe <= 1'b0;
                rx_word.fe <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr)
            A_DATA:  rdata = rx_word.data;
            A_CTRL:  rdata = {1'b0, cfg};
            A_IEN:   rdata = {6'd0, ien};
            A_STAT:  rdata = {3'd0, tx_busy, rx_word.fe, rx_word.pe, !hold_full, rx_full};
            default: rdata = '0;
        endcase
    end

    assign irq_rx = rx_full && ien[0];
    assign irq_tx = !hold_full && ien[1];

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !rx_done) |=> !rx_full);
    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_full && !take && !data_wr) |=> (hold_full && $stable(hold_data)));

endmodule

// File: tb/serial_port_core_tb.sv
module serial_port_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE = 2;
    localparam int NV = 6;
    localparam logic [7:0] V_CTRL [NV] = '{8'h00, 8'h28, 8'h71, 8'h60, 8'h21, 8'h08};
    localparam logic [7:0] V_DATA [NV] = '{8'hA5, 8'h5B, 8'hFF, 8'h80, 8'h00, 8'hC3};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       txd, rxd, irq_rx, irq_tx;
    logic       loop_en = 1'b1;
    logic       rxd_drv = 1'b1;
    int         total = 0, bad = 0;
    logic       finished = 1'b0;

    assign rxd = loop_en ? txd : rxd_drv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_port_core #(.BASE_DIV(BASE)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd),
        .irq_rx(irq_rx), .irq_tx(irq_tx));

    function automatic int bitp(input logic [7:0] c);
        return 16 * (BASE << c[2:0]);
    endfunction

    function automatic int blen(input logic [7:0] c);
        case (c[4:3])
            2'b01:   return 7;
            2'b10:   return 6;
            default: return 8;
        endcase
    endfunction

    function automatic logic [10:0] ref_frame(input logic [7:0] d, input logic [7:0] c,
                                              output int n);
        logic [10:0] f;
        logic p;
        int L;
        L = blen(c);
        f = 11'h7FF;
        f[0] = 1'b0;
        p = c[6];
        for (int i = 0; i < L; i++) begin
            f[i+1] = d[i];
            p = p ^ d[i];
        end
        if (c[5]) f[L+1] = p;
        n = 2 + L + (c[5] ? 1 : 0);
        return f;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_level(input logic lvl);
        int t = 0;
        while (txd !== lvl && t < 100000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // samples each line bit at its centre; returns at the stop bit centre
    task automatic grab(input int n, input int bp, output logic [10:0] bits);
        bits = 11'h7FF;
        wait_level(1'b0);
        repeat (bp / 2) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (bp) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    task automatic drive(input logic [10:0] bits, input int n, input int bp);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rxd_drv = bits[i];
            repeat (bp - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd_drv = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [10:0] got, exp_f;
        int          n, bp, cnt;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 txd idle", txd, 1'b1);
        chk("R10 irq_rx", irq_rx, 1'b0);
        chk("R10 irq_tx", irq_tx, 1'b0);
        rd(2'd3, v);
        chk("R10 status", v, 8'h02);

        // vector table: loopback, frame format, reception
        for (int k = 0; k < NV; k++) begin
            wr(2'd1, V_CTRL[k]);
            bp = bitp(V_CTRL[k]);
            exp_f = ref_frame(V_DATA[k], V_CTRL[k], n);
            wr(2'd0, V_DATA[k]);
            grab(n, bp, got);
            // R2 R3 R4 frame bits on the line
            chk($sformatf("R2 R3 R4 frame vec%0d", k), got, exp_f);
            repeat (bp) @(negedge clk);
            rd(2'd3, v);
            chk($sformatf("R6 status vec%0d", k), v, 8'h03);
            rd(2'd0, v);
            chk($sformatf("R3 data vec%0d", k), v, V_DATA[k] & (8'hFF >> (8 - blen(V_CTRL[k]))));
            rd(2'd3, v);
            chk($sformatf("R6 cleared vec%0d", k), v[0], 1'b0);
        end

        // R1 bit time at two rates: high data bit 0 after start
        for (int s = 0; s < 3; s += 2) begin
            wr(2'd1, 8'(s));
            wr(2'd0, 8'h01);
            wait_level(1'b0);
            wait_level(1'b1);
            cnt = 0;
            while (txd === 1'b1 && cnt < 10000) begin
                @(negedge clk);
                cnt++;
            end
            chk($sformatf("R1 bit time rate%0d", s), cnt, 16 * (BASE << s));
            repeat (12 * 16 * (BASE << s)) @(negedge clk);
            rd(2'd0, v);
        end

        // R5 back-to-back frames, R9 tx interrupt
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h02);
        chk("R9 irq_tx when empty", irq_tx, 1'b1);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h00);
        rd(2'd3, v);
        chk("R5 holding full", v[1], 1'b0);
        chk("R10 busy flag", v[4], 1'b1);
        chk("R9 irq_tx when full", irq_tx, 1'b0);
        wait_level(1'b1);
        cnt = 0;
        while (txd === 1'b1 && cnt < 10000) begin
            @(negedge clk);
            cnt++;
        end
        chk("R5 stop length between frames", cnt, bitp(8'h00));
        rd(2'd3, v);
        chk("R5 holding empty after take", v[1], 1'b1);
        repeat (12 * bitp(8'h00)) @(negedge clk);
        rd(2'd0, v);
        wr(2'd2, 8'h00);
        chk("R9 irq_tx gated", irq_tx, 1'b0);

        // R7 parity error (8 bits, even)
        loop_en = 1'b0;
        wr(2'd1, 8'h20);
        exp_f = ref_frame(8'h3C, 8'h20, n);
        exp_f[9] = ~exp_f[9];
        drive(exp_f, n, bitp(8'h20));
        rd(2'd3, v);
        chk("R7 parity error status", v, 8'h07);
        rd(2'd0, v);
        chk("R7 data with parity error", v, 8'h3C);
        rd(2'd3, v);
        chk("R7 flags cleared by read", v, 8'h02);

        // R7 framing error, then line held low (break)
        wr(2'd1, 8'h00);
        exp_f = ref_frame(8'h96, 8'h00, n);
        exp_f[9] = 1'b0;
        drive(exp_f, n - 1, bitp(8'h00));
        rxd_drv = 1'b0;
        repeat (bitp(8'h00) * 3) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (bitp(8'h00) * 2) @(negedge clk);
        rd(2'd3, v);
        chk("R7 framing error status", v, 8'h0B);
        rd(2'd0, v);
        chk("R7 data with framing error", v, 8'h96);
        rd(2'd3, v);
        chk("R7 no frame from break", v, 8'h02);

        // R8 short low pulse ignored, then a good frame still received
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (3 * BASE) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (3 * bitp(8'h00)) @(negedge clk);
        rd(2'd3, v);
        chk("R8 glitch ignored", v, 8'h02);
        wr(2'd2, 8'h01);
        chk("R9 irq_rx idle", irq_rx, 1'b0);
        exp_f = ref_frame(8'h4E, 8'h00, n);
        drive(exp_f, n, bitp(8'h00));
        chk("R9 irq_rx raised", irq_rx, 1'b1);
        rd(2'd0, v);
        chk("R8 receiver recovered", v, 8'h4E);
        chk("R9 irq_rx cleared", irq_rx, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule